// File: doc/BRIEF.md
# DAC Power-Up Sequencing Controller

This block steps the digital side of a stereo audio converter through power-up and power-down. An active-low run pin asks for power-down when it is low. The controller accepts a power-up only after the pin has been held low long enough. If the regulator strap is set, it waits out a regulator and oscillator settling interval. It then waits for the clocks that the selected mode needs, counts a fixed number of sample-rate strobes before it enables the clock divider, and holds there until software sets a go bit. All of these intervals are counted in master-clock cycles or in sample strobes, and their lengths are set by parameters.

The states are OFF (code 0), SETTLE (code 1, regulator settling), DIVWAIT (code 2, divider start delay), HOLD (code 3, divider running and waiting for the go bit) and RUN (code 4, data path live). The transitions are:
- start-regulated: OFF to SETTLE.
- start-direct: OFF to DIVWAIT.
- settled: SETTLE to DIVWAIT.
- divider-up: DIVWAIT to HOLD.
- go: HOLD to RUN.
- stop: RUN to HOLD.
- clock-lost: HOLD or RUN to DIVWAIT.
- power-down: any state to OFF, asynchronously.

The state code is exported so the order of states can be observed from outside.

Top module: `dac_pwrseq`

## Requirements
- R1: In OFF (state_code 0): core_off=1, aout_hiz=1, and reg_en=0, div_en=0, dp_en=0, zero_l=0, zero_r=0.
- R2: A power-up is accepted only after run_pin has been sampled low on at least LOW_MIN consecutive clock edges. After a shorter low pulse the block stays in OFF with reg_en=0, even once run_pin is high again.
- R3: On the first edge with run_pin high after an accepted low pulse, the block leaves OFF. It goes to SETTLE (code 1) if ldo_strap=1 and to DIVWAIT (code 2) if ldo_strap=0. From then on reg_en=1.
- R4: The block stays in SETTLE for exactly LDO_CYC clock cycles, with core_off=1 and aout_hiz=1, and then enters DIVWAIT with core_off=0 and aout_hiz=0.
- R5: The mode decides which clocks must be present. mode 0 (PCM) needs mclk_ok, bitclk_ok and wordclk_ok. mode 1 (DSD) needs mclk_ok and dsdclk_ok. mode 2 (external filter) needs mclk_ok, bitclk_ok and wordclk_ok. mode 3 is never satisfied.
- R6: In DIVWAIT, the block enters HOLD (code 3, div_en=1) on the edge that samples the DIV_FS-th fs_stb seen while the clocks are satisfied. Any cycle with the clocks unsatisfied restarts the strobe count.
- R7: HOLD goes to RUN (code 4) on an edge that samples sw_go=1, and RUN goes back to HOLD on an edge that samples sw_go=0. dp_en=1 only in RUN. div_en=1 in HOLD and RUN.
- R8: In HOLD or RUN, an edge that samples unsatisfied clocks moves the block to DIVWAIT, clearing div_en and dp_en. This takes priority over sw_go.
- R9: run_pin going low forces OFF and clears every enable at once, without waiting for a clock edge.
- R10: zero_l and zero_r follow zdet_l and zdet_r except in OFF and SETTLE, where they are 0.
- R11: reg_en is 0 whenever run_pin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Supplies-valid reset, active low, asynchronous |
| run_pin | input | 1 | Power-down pin: low requests power-down |
| ldo_strap | input | 1 | Regulator strap: 1 adds the settling phase |
| sw_go | input | 1 | Software go bit |
| mode | input | 2 | 0 PCM, 1 DSD, 2 external filter, 3 reserved |
| mclk_ok | input | 1 | Master clock present |
| bitclk_ok | input | 1 | Bit clock present |
| wordclk_ok | input | 1 | Word clock present |
| dsdclk_ok | input | 1 | DSD clock present |
| fs_stb | input | 1 | One-cycle strobe per sample period |
| zdet_l | input | 1 | Raw left zero detect |
| zdet_r | input | 1 | Raw right zero detect |
| core_off | output | 1 | Internal power-down |
| reg_en | output | 1 | Register access enable |
| div_en | output | 1 | Clock divider enable |
| dp_en | output | 1 | Data path enable |
| aout_hiz | output | 1 | Analog outputs high impedance |
| zero_l | output | 1 | Left zero-detect flag |
| zero_r | output | 1 | Right zero-detect flag |
| state_code | output | 3 | Current state code |

## Verification
Every output is decoded from the state register, so a transition shows up in the cycle that follows the edge that sampled its cause. The bench drives inputs on the falling edge and checks on the next falling edge. Intervals are checked on both sides of their boundary: SETTLE is checked after LDO_CYC-1 cycles and again after LDO_CYC, and DIVWAIT is checked after DIV_FS-1 strobes and again just after the DIV_FS-th. The asynchronous power-down is checked 1 ns after run_pin falls, before any clock edge. The clock-requirement sweep covers all four modes against all sixteen combinations of clock flags.

// File: rtl/dac_pwrseq_pkg.sv
package dac_pwrseq_pkg;

    typedef enum logic [2:0] {
        S_OFF    = 3'd0,
        S_SETTLE = 3'd1,
        S_DIVW   = 3'd2,
        S_HOLD   = 3'd3,
        S_RUN    = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        M_PCM  = 2'd0,
        M_DSD  = 2'd1,
        M_EXTF = 2'd2,
        M_RSVD = 2'd3
    } seq_mode_t;

endpackage

// File: rtl/dac_pwrseq_lowq.sv
// Qualifies the low pulse on the run pin; reset only by supplies-valid.
module dac_pwrseq_lowq #(
    parameter int LOW_MIN = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic run_pin,
    input  logic consume,
    output logic armed
);
    localparam int W = $clog2(LOW_MIN + 1);

    logic [W-1:0] low_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_cnt <= '0;
            armed   <= 1'b0;
        end else if (!run_pin) begin
            if (low_cnt == W'(LOW_MIN - 1)) armed <= 1'b1;
            else                            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
            if (consume) armed <= 1'b0;
        end
    end

    // R2: arming only happens while the pin is held low
    p_arm_needs_low_r2: assert property (@(posedge clk) disable iff (!por_n)
        $rose(armed) |-> !$past(run_pin));

endmodule

// File: rtl/dac_pwrseq_clkreq.sv
// Decides whether the clocks required by the selected mode are present.
module dac_pwrseq_clkreq
    import dac_pwrseq_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       mclk_ok,
    input  logic       bitclk_ok,
    input  logic       wordclk_ok,
    input  logic       dsdclk_ok,
    output logic       clk_ok
);
    always_comb begin
        unique case (seq_mode_t'(mode))
            M_PCM:   clk_ok = mclk_ok & wordclk_ok & bitclk_ok;
            M_DSD:   clk_ok = mclk_ok & dsdclk_ok;
            M_EXTF:  clk_ok = mclk_ok & bitclk_ok & wordclk_ok;
            default: clk_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/dac_pwrseq_tick.sv
// Terminal counter: hit on the step that reaches LAST, then wraps to zero.
module dac_pwrseq_tick #(
    parameter int LAST = 3
) (
    input  logic clk,
    input  logic arst_n,
    input  logic clr,
    input  logic step,
    output logic hit
);
    localparam int W = $clog2(LAST + 2);

    logic [W-1:0] cnt;

    assign hit = step && (cnt == W'(LAST));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          cnt <= '0;
        else if (clr || hit)  cnt <= '0;
        else if (step)        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dac_pwrseq.sv
module dac_pwrseq
    import dac_pwrseq_pkg::*;
#(
    parameter int LOW_MIN = 16,
    parameter int LDO_CYC = 48000,
    parameter int DIV_FS  = 4
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       run_pin,
    input  logic       ldo_strap,
    input  logic       sw_go,
    input  logic [1:0] mode,
    input  logic       mclk_ok,
    input  logic       bitclk_ok,
    input  logic       wordclk_ok,
    input  logic       dsdclk_ok,
    input  logic       fs_stb,
    input  logic       zdet_l,
    input  logic       zdet_r,
    output logic       core_off,
    output logic       reg_en,
    output logic       div_en,
    output logic       dp_en,
    output logic       aout_hiz,
    output logic       zero_l,
    output logic       zero_r,
    output logic [2:0] state_code
);
    seq_state_t state, state_nx;
    logic arst_n, armed, consume, clk_ok, ldo_hit, div_hit;

    assign arst_n  = por_n & run_pin;
    assign consume = (state == S_OFF) && armed;

    dac_pwrseq_lowq #(.LOW_MIN(LOW_MIN)) u_lowq (
        .clk(clk), .por_n(por_n), .run_pin(run_pin),
        .consume(consume), .armed(armed)
    );

    dac_pwrseq_clkreq u_clkreq (
        .mode(mode), .mclk_ok(mclk_ok), .bitclk_ok(bitclk_ok),
        .wordclk_ok(wordclk_ok), .dsdclk_ok(dsdclk_ok), .clk_ok(clk_ok)
    );

    dac_pwrseq_tick #(.LAST(LDO_CYC - 1)) u_ldo_tmr (
        .clk(clk), .arst_n(arst_n),
        .clr(state != S_SETTLE), .step(state == S_SETTLE), .hit(ldo_hit)
    );

    dac_pwrseq_tick #(.LAST(DIV_FS - 1)) u_div_tmr (
        .clk(clk), .arst_n(arst_n),
        .clr((state != S_DIVW) || !clk_ok),
        .step((state == S_DIVW) && clk_ok && fs_stb), .hit(div_hit)
    );

    // State register: the pin going low clears it asynchronously.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= S_OFF;
        else         state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_OFF:    if (armed) state_nx = ldo_strap ? S_SETTLE : S_DIVW;
            S_SETTLE: if (ldo_hit) state_nx = S_DIVW;
            S_DIVW:   if (div_hit) state_nx = S_HOLD;
            S_HOLD:   if (!clk_ok) state_nx = S_DIVW;
                      else if (sw_go) state_nx = S_RUN;
            S_RUN:    if (!clk_ok) state_nx = S_DIVW;
                      else if (!sw_go) state_nx = S_HOLD;
            default:  state_nx = S_OFF;
        endcase
    end

    // Output decode
    always_comb begin
        core_off = 1'b0;
        reg_en   = 1'b1;
        div_en   = 1'b0;
        dp_en    = 1'b0;
        aout_hiz = 1'b0;
        unique case (state)
            S_OFF:    begin core_off = 1'b1; reg_en = 1'b0; aout_hiz = 1'b1; end
            S_SETTLE: begin core_off = 1'b1; aout_hiz = 1'b1; end
            S_DIVW:   ;
            S_HOLD:   div_en = 1'b1;
            S_RUN:    begin div_en = 1'b1; dp_en = 1'b1; end
            default:  begin core_off = 1'b1; reg_en = 1'b0; aout_hiz = 1'b1; end
        endcase
        zero_l = zdet_l & ~core_off;
        zero_r = zdet_r & ~core_off;
    end

    assign state_code = state;

    // R11: no register access while the pin is low
    p_regen_pin_low_r11: assert property (@(posedge clk) disable iff (!por_n)
        !run_pin |-> !reg_en);

    // R3: direct entry to the divider wait only without the regulator strap
    p_skip_settle_r3: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(state) == S_OFF && state == S_DIVW) |-> !$past(ldo_strap));

    // R6: a terminal strobe count in DIVWAIT starts the divider
    p_div_start_r6: assert property (@(posedge clk) disable iff (!arst_n)
        (state == S_DIVW && div_hit) |=> state == S_HOLD);

    // R7: clearing the go bit leaves RUN
    p_go_clear_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (state == S_RUN && !sw_go && clk_ok) |=> state == S_HOLD);

    // R8: clock loss sends the block back to the divider wait
    p_clock_loss_r8: assert property (@(posedge clk) disable iff (!arst_n)
        ((state == S_HOLD || state == S_RUN) && !clk_ok) |=> state == S_DIVW);

    // R10: flags low while the outputs float
    p_hiz_flags_r10: assert property (@(posedge clk) disable iff (!por_n)
        aout_hiz |-> !(zero_l || zero_r));

endmodule

// File: tb/test_dac_pwrseq.sv
`timescale 1ns/1ps
module test_dac_pwrseq;
    localparam int LOW_MIN = 3;
    localparam int LDO_CYC = 6;
    localparam int DIV_FS  = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0, run_pin = 1'b0, ldo_strap = 1'b0, sw_go = 1'b0;
    logic [1:0] mode = 2'd0;
    logic mclk_ok = 0, bitclk_ok = 0, wordclk_ok = 0, dsdclk_ok = 0;
    logic fs_stb = 0, zdet_l = 0, zdet_r = 0;
    logic core_off, reg_en, div_en, dp_en, aout_hiz, zero_l, zero_r;
    logic [2:0] state_code;

    int vectors = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dac_pwrseq #(.LOW_MIN(LOW_MIN), .LDO_CYC(LDO_CYC), .DIV_FS(DIV_FS)) i_dac_pwrseq (
        .clk(clk), .por_n(por_n), .run_pin(run_pin), .ldo_strap(ldo_strap),
        .sw_go(sw_go), .mode(mode), .mclk_ok(mclk_ok), .bitclk_ok(bitclk_ok),
        .wordclk_ok(wordclk_ok), .dsdclk_ok(dsdclk_ok), .fs_stb(fs_stb),
        .zdet_l(zdet_l), .zdet_r(zdet_r), .core_off(core_off), .reg_en(reg_en),
        .div_en(div_en), .dp_en(dp_en), .aout_hiz(aout_hiz), .zero_l(zero_l),
        .zero_r(zero_r), .state_code(state_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_flags(input logic [3:0] f);
        mclk_ok = f[0]; bitclk_ok = f[1]; wordclk_ok = f[2]; dsdclk_ok = f[3];
    endtask

    task automatic strobe();
        fs_stb = 1'b1; cyc(1); fs_stb = 1'b0; cyc(1);
    endtask

    task automatic power_up();
        run_pin = 1'b0; cyc(LOW_MIN); run_pin = 1'b1; cyc(1);
    endtask

    function automatic logic exp_ok(input logic [1:0] m, input logic [3:0] f);
        case (m)
            2'd0:    return f[0] & f[1] & f[2];
            2'd1:    return f[0] & f[3];
            2'd2:    return f[0] & f[1] & f[2];
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        zdet_l = 1'b1; zdet_r = 1'b1;
        cyc(3);
        // R1: power-off outputs
        chk("R1 state", state_code, 0);
        chk("R1 core_off", core_off, 1);
        chk("R1 aout_hiz", aout_hiz, 1);
        chk("R1 reg_en", reg_en, 0);
        chk("R1 div_en", div_en, 0);
        chk("R1 dp_en", dp_en, 0);
        chk("R1 zero_l", zero_l, 0);
        chk("R1 zero_r", zero_r, 0);

        run_pin = 1'b1; por_n = 1'b1; cyc(5);
        chk("R2 no pulse yet state", state_code, 0);
        chk("R2 no pulse yet reg_en", reg_en, 0);

        run_pin = 1'b0; cyc(LOW_MIN - 1); run_pin = 1'b1; cyc(5);
        chk("R2 short pulse state", state_code, 0);
        chk("R2 short pulse reg_en", reg_en, 0);

        ldo_strap = 1'b1;
        power_up();
        chk("R3 enter settle", state_code, 1);
        chk("R3 reg_en", reg_en, 1);
        chk("R4 core_off in settle", core_off, 1);
        chk("R10 flags in settle", {zero_l, zero_r}, 2'b00);
        cyc(LDO_CYC - 1);
        chk("R4 still settling", state_code, 1);
        chk("R4 hiz in settle", aout_hiz, 1);
        cyc(1);
        chk("R4 settle done", state_code, 2);
        chk("R4 core_off released", core_off, 0);
        chk("R4 hiz released", aout_hiz, 0);
        chk("R6 div_en in wait", div_en, 0);
        chk("R10 flags follow", {zero_l, zero_r}, 2'b11);

        // R5 sweep: every mode against every clock-flag combination
        for (int m = 0; m < 4; m++) begin
            for (int f = 0; f < 16; f++) begin
                mode = 2'(m); set_flags(4'(f));
                repeat (DIV_FS) strobe();
                chk($sformatf("R5 mode%0d flags%0h", m, f), state_code,
                    exp_ok(2'(m), 4'(f)) ? 3 : 2);
                set_flags(4'h0); cyc(1);
                chk("R8 drop returns to wait", state_code, 2);
            end
        end

        // R6: count restarts when clocks vanish for a cycle
        mode = 2'd0; set_flags(4'h7);
        strobe(); strobe();
        mclk_ok = 1'b0; cyc(1); mclk_ok = 1'b1;
        repeat (DIV_FS - 1) strobe();
        chk("R6 count restarted", state_code, 2);
        fs_stb = 1'b1; cyc(1); fs_stb = 1'b0;
        chk("R6 divider up", state_code, 3);
        chk("R6 div_en", div_en, 1);
        chk("R7 dp_en in hold", dp_en, 0);

        // R7: software go gate
        cyc(4);
        chk("R7 holds without go", state_code, 3);
        sw_go = 1'b1; cyc(1);
        chk("R7 run", state_code, 4);
        chk("R7 dp_en", dp_en, 1);
        sw_go = 1'b0; cyc(1);
        chk("R7 back to hold", state_code, 3);
        sw_go = 1'b1; cyc(1);
        chk("R7 run again", state_code, 4);

        // R8: clock loss in run, then recovery
        wordclk_ok = 1'b0; cyc(1);
        chk("R8 loss state", state_code, 2);
        chk("R8 loss div_en", div_en, 0);
        chk("R8 loss dp_en", dp_en, 0);
        wordclk_ok = 1'b1;
        repeat (DIV_FS - 1) strobe();
        chk("R8 waiting again", state_code, 2);
        fs_stb = 1'b1; cyc(1); fs_stb = 1'b0;
        chk("R8 divider again", state_code, 3);
        cyc(1);
        chk("R8 run again", state_code, 4);

        zdet_l = 1'b1; zdet_r = 1'b0; #1;
        chk("R10 left flag", zero_l, 1);
        chk("R10 right flag", zero_r, 0);
        zdet_r = 1'b1; cyc(1);

        // R9: asynchronous power-down, checked before any edge
        run_pin = 1'b0; #1;
        chk("R9 state", state_code, 0);
        chk("R9 div_en", div_en, 0);
        chk("R9 dp_en", dp_en, 0);
        chk("R9 hiz", aout_hiz, 1);
        chk("R11 reg_en", reg_en, 0);
        chk("R10 flags off", {zero_l, zero_r}, 2'b00);
        cyc(1);
        run_pin = 1'b1; cyc(4);
        chk("R2 short after run", state_code, 0);
        chk("R2 short reg_en", reg_en, 0);

        ldo_strap = 1'b0;
        power_up();
        chk("R3 direct to wait", state_code, 2);
        chk("R3 direct core_off", core_off, 0);
        chk("R3 direct reg_en", reg_en, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule